// File: doc/BRIEF.md
# MCU Reset and Brown-out Controller

This block produces the system reset and brown-out event signals for a small 8-bit microcontroller core. Four things can start it. A power-on indication resets everything. An external active-high reset pin is synchronized and must be held for a qualifying run of clocks. Software can start a reset by raising a control bit. A digital brown-out flag coming from an analog comparator is the fourth source. Once a reset fires, the block holds the core in reset for a fixed stretch and presents the restart address on the program-counter load output.

A brown-out has two possible outcomes, chosen by an enable bit that software controls. With the enable set, a qualified brown-out raises a level interrupt request carrying its own vector, and the core keeps running. With the enable clear, the same brown-out resets the core. If software clears the enable while the brown-out is still present, the core is reset. During a software-started reset the block drives a retention mask. The register file uses this mask to keep the software-reset bit and the watchdog status bit. A power-on flag is set at power-up and is cleared only by an explicit software write.

Top module: `mcu_rst_ctrl`

## Requirements
- R1: The reset pin passes through two synchronizer flops and counts only once 24 consecutive high samples have been seen; a run of 23 samples causes no reset. When the pin is sampled high for exactly 24 clocks, core_rst_o rises 27 clock edges after the first high sample edge.
- R2: After power-on release, core_rst_o stays high for 24 clocks. A triggered reset holds core_rst_o high for 24 clocks after its last trigger cycle, and for as long as the qualified pin stays high.
- R3: pc_load_o always carries restart address 16'h0000.
- R4: A write to address 8'hB2 with data bit 1 set starts a software reset, but only when the stored software-reset bit is 0. Writing bit 1 = 1 while the stored bit is already 1 has no effect.
- R5: keep_mask_o reads 2'b11 throughout a software-started reset and 2'b00 otherwise. Bit 0 retains the software-reset bit and bit 1 retains the watchdog status bit. The stored software-reset bit survives a software reset, and a pin or brown-out reset clears it.
- R6: A brown-out counts only after bo_flag_i has been sampled high on 4 consecutive clocks; shorter pulses cause neither a reset nor an interrupt.
- R7: With the brown-out enable set (address 8'hE8, bit 3), a qualified brown-out raises bo_irq_o on the same edge that completes qualification. bo_vec_o reads 16'h004B, and core_rst_o stays low.
- R8: bo_irq_o stays high until irq_ack_i is sampled or the enable is cleared. It is raised again only after bo_flag_i has dropped and then qualified once more.
- R9: With the enable clear, a qualified brown-out asserts core_rst_o one edge after qualification. The reset is held while the brown-out lasts and for 24 clocks after it ends.
- R10: Clearing the enable while a qualified brown-out is present drops bo_irq_o at once and asserts core_rst_o one edge later.
- R11: pof_o is set by power-on and is cleared only by writing address 8'h87 with bit 4 = 0. Writing that bit as 1 has no effect, and pin and software resets leave pof_o unchanged.
- R12: Register writes are ignored while core_rst_o is high. Every pin, brown-out or software reset clears the brown-out enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| bo_flag_i | input | 1 | Brown-out comparator flag, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| irq_ack_i | input | 1 | Brown-out interrupt acknowledge |
| core_rst_o | output | 1 | Core reset, active high |
| pc_load_o | output | 16 | Program-counter load address used on reset |
| bo_irq_o | output | 1 | Brown-out interrupt request level |
| bo_vec_o | output | 16 | Brown-out interrupt vector |
| keep_mask_o | output | 2 | Register bits retained through a software reset |
| pof_o | output | 1 | Power-on flag |

## Verification
An error in a qualification counter shows up as a core reset edge one or more clocks away from the 27-edge pin latency or the 5-edge brown-out latency. It can also show up as a reset that fires on a pulse one sample too short. An error in the stretch counter changes the 24-clock reset width, which a check at the last high cycle and the first low cycle detects. An error in the stored software-reset or enable bit shows up in the next stimulus: a software reset that fires twice or never, or a brown-out that produces an interrupt where a reset is due. The bench drives that stimulus right after the corrupting event.

// File: rtl/rst_pkg.sv
`timescale 1ns/1ps
package rst_pkg;

    // Stored control state of the reset controller
    typedef struct packed {
        logic swr;       // software-reset request bit (retained through its own reset)
        logic ebo;       // brown-out interrupt enable
        logic pof;       // power-on flag
        logic irq;       // brown-out interrupt request level
        logic cause_sw;  // current reset was started by software
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{swr: 1'b0, ebo: 1'b0, pof: 1'b1,
                                         irq: 1'b0, cause_sw: 1'b0};

endpackage

// File: rtl/rst_qual.sv
`timescale 1ns/1ps
module rst_qual #(
    parameter int SYNC = 2,
    parameter int QUAL = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    output logic qual_o,
    output logic rise_o
);
    localparam int CW = $clog2(QUAL + 1);

    logic in_s;

    generate
        if (SYNC == 0) begin : g_direct
            assign in_s = in_i;
        end else begin : g_sync
            logic [SYNC-1:0] sh_d, sh_q;
            always_comb sh_d = (sh_q << 1) | SYNC'(in_i);
            always_ff @(posedge clk or posedge rst) begin
                if (rst) sh_q <= '0;
                else     sh_q <= sh_d;
            end
            assign in_s = sh_q[SYNC-1];
        end
    endgenerate

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_state_t;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!in_s)                    st_d.cnt = '0;
        else if (st_q.cnt != CW'(QUAL)) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign qual_o = (st_q.cnt == CW'(QUAL));
    assign rise_o = in_s && (st_q.cnt == CW'(QUAL - 1));

endmodule

// File: rtl/rst_stretch.sv
`timescale 1ns/1ps
module rst_stretch #(
    parameter int LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic active_o
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_state_t;

    str_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i)              st_d.cnt = CW'(LEN);
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{cnt: CW'(LEN)};
        else     st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);

endmodule

// File: rtl/rst_regs.sv
`timescale 1ns/1ps
module rst_regs
    import rst_pkg::*;
#(
    parameter logic [7:0] SWR_ADDR = 8'hB2,
    parameter int         SWR_BIT  = 1,
    parameter logic [7:0] EBO_ADDR = 8'hE8,
    parameter int         EBO_BIT  = 3,
    parameter logic [7:0] PCF_ADDR = 8'h87,
    parameter int         POF_BIT  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       irq_ack_i,
    input  logic       core_rst_i,
    input  logic       pin_qual_i,
    input  logic       bo_qual_i,
    input  logic       bo_rise_i,
    output logic       swr_fire_o,
    output logic       hw_rst_o,
    output logic       irq_o,
    output logic       pof_o,
    output logic       keep_o
);
    ctl_state_t st_d, st_q;
    logic wr_ok;

    always_comb begin
        st_d       = st_q;
        wr_ok      = wr_en_i && !core_rst_i;
        swr_fire_o = wr_ok && (wr_addr_i == SWR_ADDR) && wr_data_i[SWR_BIT] && !st_q.swr;
        hw_rst_o   = pin_qual_i || (bo_qual_i && !st_q.ebo);

        if (wr_ok) begin
            if (wr_addr_i == SWR_ADDR) st_d.swr = wr_data_i[SWR_BIT];
            if (wr_addr_i == EBO_ADDR) st_d.ebo = wr_data_i[EBO_BIT];
            if (wr_addr_i == PCF_ADDR && !wr_data_i[POF_BIT]) st_d.pof = 1'b0;
        end

        if (bo_rise_i && st_q.ebo) st_d.irq = 1'b1;
        else if (irq_ack_i)        st_d.irq = 1'b0;
        if (!st_d.ebo)             st_d.irq = 1'b0;

        if (!core_rst_i) st_d.cause_sw = 1'b0;

        if (swr_fire_o) begin
            st_d.ebo      = 1'b0;
            st_d.irq      = 1'b0;
            st_d.cause_sw = 1'b1;
        end

        if (hw_rst_o) begin
            st_d.swr      = 1'b0;
            st_d.ebo      = 1'b0;
            st_d.irq      = 1'b0;
            st_d.cause_sw = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= CTL_RESET;
        else     st_q <= st_d;
    end

    assign irq_o  = st_q.irq;
    assign pof_o  = st_q.pof;
    assign keep_o = st_q.cause_sw && core_rst_i;

endmodule

// File: rtl/mcu_rst_ctrl.sv
`timescale 1ns/1ps
module mcu_rst_ctrl #(
    parameter int          PIN_SYNC = 2,
    parameter int          PIN_QUAL = 24,
    parameter int          BO_QUAL  = 4,
    parameter int          RST_LEN  = 24,
    parameter logic [15:0] RST_VEC  = 16'h0000,
    parameter logic [15:0] BO_VEC   = 16'h004B
) (
    input  logic        clk,
    input  logic        por_i,
    input  logic        rst_pin_i,
    input  logic        bo_flag_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_addr_i,
    input  logic [7:0]  wr_data_i,
    input  logic        irq_ack_i,
    output logic        core_rst_o,
    output logic [15:0] pc_load_o,
    output logic        bo_irq_o,
    output logic [15:0] bo_vec_o,
    output logic [1:0]  keep_mask_o,
    output logic        pof_o
);
    logic pin_qual, pin_rise, bo_qual, bo_rise;
    logic swr_fire, hw_rst, keep;

    rst_qual #(.SYNC(PIN_SYNC), .QUAL(PIN_QUAL)) u_pin (
        .clk(clk), .rst(por_i), .in_i(rst_pin_i),
        .qual_o(pin_qual), .rise_o(pin_rise));

    rst_qual #(.SYNC(0), .QUAL(BO_QUAL)) u_bo (
        .clk(clk), .rst(por_i), .in_i(bo_flag_i),
        .qual_o(bo_qual), .rise_o(bo_rise));

    rst_regs u_regs (
        .clk(clk), .rst(por_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .irq_ack_i(irq_ack_i), .core_rst_i(core_rst_o),
        .pin_qual_i(pin_qual), .bo_qual_i(bo_qual), .bo_rise_i(bo_rise),
        .swr_fire_o(swr_fire), .hw_rst_o(hw_rst),
        .irq_o(bo_irq_o), .pof_o(pof_o), .keep_o(keep));

    rst_stretch #(.LEN(RST_LEN)) u_str (
        .clk(clk), .rst(por_i), .trig_i(swr_fire || hw_rst),
        .active_o(core_rst_o));

    assign pc_load_o   = RST_VEC;
    assign bo_vec_o    = BO_VEC;
    assign keep_mask_o = {2{keep}};

endmodule

// File: rtl/rst_ctrl_chk.sv
`timescale 1ns/1ps
module rst_ctrl_chk (
    input logic       clk,
    input logic       por_i,
    input logic       pin_rise,
    input logic       pin_qual,
    input logic       bo_qual,
    input logic       swr_fire,
    input logic       hw_rst,
    input logic       core_rst_o,
    input logic       bo_irq_o,
    input logic [1:0] keep_mask_o,
    input logic       pof_o,
    input logic       wr_en_i,
    input logic [7:0] wr_addr_i,
    input logic [7:0] wr_data_i
);
    assert_pin_rise_R1: assert property (@(posedge clk) disable iff (por_i)
        pin_rise |=> pin_qual);

    assert_hw_hold_R2: assert property (@(posedge clk) disable iff (por_i)
        hw_rst |=> core_rst_o);

    assert_sw_keep_R5: assert property (@(posedge clk) disable iff (por_i)
        swr_fire |=> (core_rst_o && keep_mask_o == 2'b11));

    assert_keep_in_rst_R5: assert property (@(posedge clk) disable iff (por_i)
        (keep_mask_o != 2'b00) |-> core_rst_o);

    assert_irq_qual_R7: assert property (@(posedge clk) disable iff (por_i)
        $rose(bo_irq_o) |-> (bo_qual && !core_rst_o));

    assert_pof_clear_R11: assert property (@(posedge clk) disable iff (por_i)
        $fell(pof_o) |-> $past(wr_en_i && !core_rst_o && wr_addr_i == 8'h87 && !wr_data_i[4]));
endmodule

bind mcu_rst_ctrl rst_ctrl_chk u_chk (
    .clk(clk), .por_i(por_i), .pin_rise(pin_rise), .pin_qual(pin_qual),
    .bo_qual(bo_qual), .swr_fire(swr_fire), .hw_rst(hw_rst),
    .core_rst_o(core_rst_o), .bo_irq_o(bo_irq_o), .keep_mask_o(keep_mask_o),
    .pof_o(pof_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i));

// File: tb/tb_mcu_rst_ctrl.sv
`timescale 1ns/1ps
module tb_mcu_rst_ctrl;
    logic        clk = 1'b0;
    logic        por_i = 1'b1;
    logic        rst_pin_i = 1'b0;
    logic        bo_flag_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        irq_ack_i = 1'b0;
    logic        core_rst_o;
    logic [15:0] pc_load_o;
    logic        bo_irq_o;
    logic [15:0] bo_vec_o;
    logic [1:0]  keep_mask_o;
    logic        pof_o;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    mcu_rst_ctrl dut (
        .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i), .bo_flag_i(bo_flag_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .irq_ack_i(irq_ack_i), .core_rst_o(core_rst_o), .pc_load_o(pc_load_o),
        .bo_irq_o(bo_irq_o), .bo_vec_o(bo_vec_o), .keep_mask_o(keep_mask_o),
        .pof_o(pof_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Watch n cycles; report whether core reset or irq ever rose
    task automatic quiet(input string req, input int n, input logic watch_irq);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (core_rst_o || (watch_irq && bo_irq_o)) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic t_power_on;
        tick(3);
        por_i = 1'b0;
        chk("R2 por reset", {31'd0, core_rst_o}, 1);
        chk("R11 pof set", {31'd0, pof_o}, 1);
        chk("R3 pc load", {16'd0, pc_load_o}, 32'h0000);
        chk("R5 keep idle", {30'd0, keep_mask_o}, 0);
        tick(23);
        chk("R2 por last cycle", {31'd0, core_rst_o}, 1);
        tick(1);
        chk("R2 por end", {31'd0, core_rst_o}, 0);
    endtask

    task automatic t_pin_short;
        rst_pin_i = 1'b1; tick(23); rst_pin_i = 1'b0;
        quiet("R1 23-sample pin ignored", 40, 1'b0);
    endtask

    task automatic t_pin_exact;
        rst_pin_i = 1'b1; tick(24); rst_pin_i = 1'b0;
        tick(2);
        chk("R1 pin latency before", {31'd0, core_rst_o}, 0);
        tick(1);
        chk("R1 pin latency at", {31'd0, core_rst_o}, 1);
        chk("R3 pc load on pin", {16'd0, pc_load_o}, 32'h0000);
        tick(23);
        chk("R2 pin stretch last", {31'd0, core_rst_o}, 1);
        tick(1);
        chk("R2 pin stretch end", {31'd0, core_rst_o}, 0);
    endtask

    task automatic t_pin_long;
        rst_pin_i = 1'b1; tick(60);
        chk("R2 held while pin high", {31'd0, core_rst_o}, 1);
        wr(8'h87, 8'h00);
        chk("R12 write ignored in reset", {31'd0, pof_o}, 1);
        rst_pin_i = 1'b0; tick(60);
        chk("R2 pin long end", {31'd0, core_rst_o}, 0);
        chk("R11 pof kept over pin", {31'd0, pof_o}, 1);
    endtask

    task automatic t_sw;
        wr(8'hB2, 8'h02);
        chk("R4 sw reset fires", {31'd0, core_rst_o}, 1);
        chk("R5 keep during sw", {30'd0, keep_mask_o}, 3);
        tick(23);
        chk("R4 sw reset last", {31'd0, core_rst_o}, 1);
        chk("R5 keep last", {30'd0, keep_mask_o}, 3);
        tick(1);
        chk("R4 sw reset end", {31'd0, core_rst_o}, 0);
        chk("R5 keep cleared", {30'd0, keep_mask_o}, 0);
        chk("R11 pof kept over sw", {31'd0, pof_o}, 1);
        wr(8'hB2, 8'h02);
        quiet("R5 swr bit retained, rewrite of 1 ignored R4", 30, 1'b0);
        wr(8'hB2, 8'h00);
        wr(8'hB2, 8'h02);
        chk("R4 sw reset after 0 then 1", {31'd0, core_rst_o}, 1);
        tick(30);
    endtask

    task automatic t_pin_clears_swr;
        rst_pin_i = 1'b1; tick(30); rst_pin_i = 1'b0; tick(60);
        wr(8'hB2, 8'h02);
        chk("R5 pin reset cleared swr bit", {31'd0, core_rst_o}, 1);
        chk("R5 keep after pin clear", {30'd0, keep_mask_o}, 3);
        tick(30);
    endtask

    task automatic t_pof;
        wr(8'h87, 8'h10);
        chk("R11 writing 1 keeps pof", {31'd0, pof_o}, 1);
        wr(8'h87, 8'h00);
        chk("R11 pof cleared", {31'd0, pof_o}, 0);
        rst_pin_i = 1'b1; tick(30); rst_pin_i = 1'b0; tick(60);
        chk("R11 pof stays clear over pin", {31'd0, pof_o}, 0);
    endtask

    task automatic t_bo_short;
        bo_flag_i = 1'b1; tick(3); bo_flag_i = 1'b0;
        quiet("R6 3-clock brown-out ignored", 30, 1'b1);
    endtask

    task automatic t_bo_rst;
        bo_flag_i = 1'b1; tick(4);
        chk("R9 bo reset before", {31'd0, core_rst_o}, 0);
        tick(1);
        chk("R9 bo reset at", {31'd0, core_rst_o}, 1);
        chk("R7 no irq in reset mode", {31'd0, bo_irq_o}, 0);
        tick(20);
        bo_flag_i = 1'b0;
        tick(24);
        chk("R9 bo stretch last", {31'd0, core_rst_o}, 1);
        tick(1);
        chk("R9 bo stretch end", {31'd0, core_rst_o}, 0);
    endtask

    task automatic t_bo_irq;
        wr(8'hE8, 8'h08);
        bo_flag_i = 1'b1; tick(3);
        chk("R6 irq before qual", {31'd0, bo_irq_o}, 0);
        tick(1);
        chk("R7 irq raised", {31'd0, bo_irq_o}, 1);
        chk("R7 vector", {16'd0, bo_vec_o}, 32'h004B);
        chk("R7 no reset", {31'd0, core_rst_o}, 0);
        tick(20);
        chk("R8 irq level held", {31'd0, bo_irq_o}, 1);
        chk("R7 core runs", {31'd0, core_rst_o}, 0);
        irq_ack_i = 1'b1; tick(1); irq_ack_i = 1'b0;
        chk("R8 ack clears", {31'd0, bo_irq_o}, 0);
        tick(10);
        chk("R8 no re-raise while present", {31'd0, bo_irq_o}, 0);
        bo_flag_i = 1'b0; tick(2);
        bo_flag_i = 1'b1; tick(4);
        chk("R8 re-raised after requalify", {31'd0, bo_irq_o}, 1);
        wr(8'hE8, 8'h00);
        chk("R10 enable clear drops irq", {31'd0, bo_irq_o}, 0);
        chk("R10 reset not yet", {31'd0, core_rst_o}, 0);
        tick(1);
        chk("R10 reset on enable clear", {31'd0, core_rst_o}, 1);
        tick(10);
        bo_flag_i = 1'b0; tick(40);
        chk("R10 reset ends", {31'd0, core_rst_o}, 0);
    endtask

    task automatic t_sw_clears_ebo;
        wr(8'hE8, 8'h08);
        wr(8'hB2, 8'h00);
        wr(8'hB2, 8'h02);
        tick(30);
        bo_flag_i = 1'b1; tick(5);
        chk("R12 sw reset cleared enable", {31'd0, core_rst_o}, 1);
        chk("R12 no irq after sw reset", {31'd0, bo_irq_o}, 0);
        bo_flag_i = 1'b0; tick(40);
    endtask

    initial begin
        t_power_on();
        t_pin_short();
        t_pin_exact();
        t_pin_long();
        t_sw();
        t_pin_clears_swr();
        t_pof();
        t_bo_short();
        t_bo_rst();
        t_bo_irq();
        t_sw_clears_ebo();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule